// File: doc/BRIEF.md
# Private Peripheral Region Address Decoder

This block sits in front of a 4 KB region of per-core private registers in a multicore cluster. Each single-cycle 32-bit access carries an offset, a read/write flag, write data and the ID of the core that issued it. The block works out which target the access is for and drives a select, a sub-offset and an instance index toward that target. The targets are a small local snoop-control register set, the interrupt-controller CPU interfaces (external) and eight private timers arranged as one timer/watchdog pair per core (external). It then returns the read data of the chosen target.

The interrupt CPU interfaces and the timer pairs each have two ways in. The first is a "this core" alias page, which resolves to the instance that belongs to the requesting core. The second is a run of banked pages, one per core, which resolve to the core numbered by the page. An access beyond the last timer page gets nothing and raises a one-cycle error flag in the same cycle as the access.

Decoding and read-data muxing are combinational. The only storage is the one-bit snoop control register.

Top module: `ppr_decoder`

## Requirements
- R1: After reset, the read data of a read at offset 0x000 is 0.
- R2: A write to offsets 0x000–0x003 stores write-data bit 0 in the control register. Only bit 0 is kept. From the next cycle, reads at those offsets return the stored bit in bit 0, with the upper bits zero.
- R3: A read at 0x004–0x007 returns the configuration word (NCORE−1 in bits [1:0], the other bits zero). A read at 0x008–0x00B returns the core_state input, zero-extended. Writes to these offsets, and to the invalidate offset 0x00C, leave the control register unchanged.
- R4: Reads at snoop-control offsets 0x00C–0x0FF return 0, with rsp_err low and no target select.
- R5: An access at 0x100–0x1FF asserts ic_sel with ic_core equal to req_core and ic_off equal to address bits [7:0].
- R6: An access at 0x200–0x5FF asserts ic_sel with ic_core = (offset − 0x200) >> 8 and ic_off equal to address bits [7:0].
- R7: An access at 0x600–0x6FF asserts tm_sel with tm_idx = req_core × 2 + address bit 5 and tm_off equal to address bits [3:0].
- R8: An access at 0x700–0xAFF asserts tm_sel with tm_idx = ((offset − 0x700) >> 8) × 2 + address bit 5 and tm_off equal to address bits [3:0].
- R9: An access at 0xB00 or above raises rsp_err in the same cycle, with no select, read data 0 and no change to the control register. rsp_err is low for every other access.
- R10: A read that selects an interrupt interface returns ic_rdata, and one that selects a timer returns tm_rdata.
- R11: At most one of ic_sel, tm_sel and rsp_err is high at a time, and all three are low when req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the region |
| req_wdata | input | 32 | Write data |
| req_core | input | 2 | ID of the requesting core |
| core_state | input | 8 | Per-core status, 2 bits per core, shown in the status register |
| ic_sel | output | 1 | Interrupt CPU interface selected |
| ic_core | output | 2 | Interrupt interface instance |
| ic_off | output | 8 | Offset inside the interrupt interface |
| ic_rdata | input | 32 | Read data from the selected interrupt interface |
| tm_sel | output | 1 | Timer selected |
| tm_idx | output | 3 | Timer instance (core × 2 + watchdog select) |
| tm_off | output | 4 | Offset inside the timer |
| tm_rdata | input | 32 | Read data from the selected timer |
| tgt_write | output | 1 | Write flag forwarded to the targets |
| tgt_wdata | output | 32 | Write data forwarded to the targets |
| rsp_rdata | output | 32 | Read data of the current access |
| rsp_err | output | 1 | Bad-offset pulse, aligned with the strobe |

## Verification
One access can hit both the error detection and the control-register write path. A write at 0xB00 or 0xF00 has address bits [7:0] equal to zero, the same low bits as the control register. It must raise rsp_err and must not store anything. The bench first sets the control bit. It then issues such out-of-range writes, directed and random, with data that would clear the bit. Each time it checks the error pulse in that cycle, then reads offset 0 and compares the result with its own model of the register.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
    typedef enum logic [1:0] {
        TGT_SCU = 2'd0,
        TGT_IC  = 2'd1,
        TGT_TMR = 2'd2,
        TGT_BAD = 2'd3
    } tgt_e;

    typedef struct packed {
        logic ctl;
    } scu_state_t;
endpackage

// File: rtl/ppr_window_decode.sv
`timescale 1ns/1ps
module ppr_window_decode
    import ppr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int PAGE_W = 4,
    parameter int CORE_W = $clog2(NCORE)
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [CORE_W-1:0] req_core,
    output tgt_e              tgt,
    output logic [CORE_W-1:0] core
);
    localparam logic [PAGE_W-1:0] IC_ALIAS_PG = PAGE_W'(1);
    localparam logic [PAGE_W-1:0] IC_BANK_PG  = PAGE_W'(2);
    localparam logic [PAGE_W-1:0] TM_ALIAS_PG = PAGE_W'(2 + NCORE);
    localparam logic [PAGE_W-1:0] TM_BANK_PG  = PAGE_W'(3 + NCORE);
    localparam logic [PAGE_W-1:0] END_PG      = PAGE_W'(3 + 2 * NCORE);

    logic [PAGE_W-1:0] ic_rel;
    logic [PAGE_W-1:0] tm_rel;

    always_comb begin
        ic_rel = page - IC_BANK_PG;
        tm_rel = page - TM_BANK_PG;
        tgt    = TGT_BAD;
        core   = '0;
        if (page == '0) begin
            tgt = TGT_SCU;
        end else if (page == IC_ALIAS_PG) begin
            tgt  = TGT_IC;
            core = req_core;
        end else if (page < TM_ALIAS_PG) begin
            tgt  = TGT_IC;
            core = ic_rel[CORE_W-1:0];
        end else if (page == TM_ALIAS_PG) begin
            tgt  = TGT_TMR;
            core = req_core;
        end else if (page < END_PG) begin
            tgt  = TGT_TMR;
            core = tm_rel[CORE_W-1:0];
        end
    end
endmodule

// File: rtl/ppr_scu_regs.sv
`timescale 1ns/1ps
module ppr_scu_regs
    import ppr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               wr,
    input  logic [5:0]         word,
    input  logic               ctl_in,
    input  logic [2*NCORE-1:0] core_state,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [5:0] W_CTL  = 6'd0;
    localparam logic [5:0] W_CFG  = 6'd1;
    localparam logic [5:0] W_STAT = 6'd2;
    localparam logic [DATA_W-1:0] CFG_WORD = DATA_W'(NCORE - 1);

    scu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc && wr && word == W_CTL) begin
            st_d.ctl = ctl_in;
        end
        unique case (word)
            W_CTL:   rdata = DATA_W'(st_q.ctl);
            W_CFG:   rdata = CFG_WORD;
            W_STAT:  rdata = DATA_W'(core_state);
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ppr_decoder.sv
`timescale 1ns/1ps
module ppr_decoder
    import ppr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int CORE_W = $clog2(NCORE),
    localparam int TIDX_W = CORE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [2*NCORE-1:0] core_state,
    output logic               ic_sel,
    output logic [CORE_W-1:0]  ic_core,
    output logic [7:0]         ic_off,
    input  logic [DATA_W-1:0]  ic_rdata,
    output logic               tm_sel,
    output logic [TIDX_W-1:0]  tm_idx,
    output logic [3:0]         tm_off,
    input  logic [DATA_W-1:0]  tm_rdata,
    output logic               tgt_write,
    output logic [DATA_W-1:0]  tgt_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err
);
    localparam int PAGE_LSB = 8;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int WDOG_BIT = 5;

    tgt_e              tgt;
    logic [CORE_W-1:0] win_core;
    logic [DATA_W-1:0] scu_rdata;
    logic              scu_acc;

    ppr_window_decode #(
        .NCORE  (NCORE),
        .PAGE_W (PAGE_W),
        .CORE_W (CORE_W)
    ) u_win (
        .page     (req_addr[ADDR_W-1:PAGE_LSB]),
        .req_core (req_core),
        .tgt      (tgt),
        .core     (win_core)
    );

    assign scu_acc = req_valid && (tgt == TGT_SCU);

    ppr_scu_regs #(
        .NCORE  (NCORE),
        .DATA_W (DATA_W)
    ) u_scu (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (scu_acc),
        .wr         (req_write),
        .word       (req_addr[7:2]),
        .ctl_in     (req_wdata[0]),
        .core_state (core_state),
        .rdata      (scu_rdata)
    );

    always_comb begin
        ic_sel    = req_valid && (tgt == TGT_IC);
        tm_sel    = req_valid && (tgt == TGT_TMR);
        rsp_err   = req_valid && (tgt == TGT_BAD);
        ic_core   = win_core;
        ic_off    = req_addr[7:0];
        tm_idx    = {win_core, req_addr[WDOG_BIT]};
        tm_off    = req_addr[3:0];
        tgt_write = req_write;
        tgt_wdata = req_wdata;
        rsp_rdata = '0;
        if (req_valid) begin
            unique case (tgt)
                TGT_SCU: rsp_rdata = scu_rdata;
                TGT_IC:  rsp_rdata = ic_rdata;
                TGT_TMR: rsp_rdata = tm_rdata;
                default: rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppr_decoder_chk.sv
`timescale 1ns/1ps
module ppr_decoder_chk #(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CORE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               wbit,
    input logic [CORE_W-1:0]  req_core,
    input logic               ic_sel,
    input logic [CORE_W-1:0]  ic_core,
    input logic               tm_sel,
    input logic [CORE_W:0]    tm_idx,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               rsp_err
);
    localparam logic [ADDR_W-1:0] BAD_BASE = ADDR_W'((3 + 2 * NCORE) * 256);
    localparam logic [ADDR_W-9:0] TM_ALIAS = (ADDR_W-8)'(2 + NCORE);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_sel, tm_sel, rsp_err})); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(ic_sel || tm_sel || rsp_err)); // R11
    AST_BAD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= BAD_BASE) |-> (rsp_err && rsp_rdata == '0)); // R9
    AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (req_valid && req_addr >= BAD_BASE)); // R9
    AST_IC_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) |-> (ic_sel && ic_core == req_core)); // R5
    AST_TM_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:8] == TM_ALIAS) |-> (tm_sel && tm_idx == {req_core, req_addr[5]})); // R7
    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0 &&
         $past(req_valid && req_write && req_addr == '0)) |-> (rsp_rdata == DATA_W'($past(wbit)))); // R2
endmodule

bind ppr_decoder ppr_decoder_chk #(
    .NCORE  (NCORE),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CORE_W (CORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wbit      (req_wdata[0]),
    .req_core  (req_core),
    .ic_sel    (ic_sel),
    .ic_core   (ic_core),
    .tm_sel    (tm_sel),
    .tm_idx    (tm_idx),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/ppr_decoder_bench.sv
`timescale 1ns/1ps
module ppr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_core = '0;
    logic [7:0]  core_state = '0;
    logic [31:0] ic_rdata = '0;
    logic [31:0] tm_rdata = '0;
    logic        ic_sel, tm_sel, tgt_write, rsp_err;
    logic [1:0]  ic_core;
    logic [7:0]  ic_off;
    logic [2:0]  tm_idx;
    logic [3:0]  tm_off;
    logic [31:0] tgt_wdata, rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic ctl_m = 1'b0;

    always #2 clk = ~clk;

    ppr_decoder u_ppr_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
        .core_state(core_state), .ic_sel(ic_sel), .ic_core(ic_core),
        .ic_off(ic_off), .ic_rdata(ic_rdata), .tm_sel(tm_sel), .tm_idx(tm_idx),
        .tm_off(tm_off), .tm_rdata(tm_rdata), .tgt_write(tgt_write),
        .tgt_wdata(tgt_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, req_addr, act, exp);
        end
    endtask

    // region: 0 scu, 1 ic alias, 2 ic bank, 3 tm alias, 4 tm bank, 5 bad
    function automatic int region_of(input int a);
        if (a < 'h100) return 0;
        if (a < 'h200) return 1;
        if (a < 'h600) return 2;
        if (a < 'h700) return 3;
        if (a < 'hB00) return 4;
        return 5;
    endfunction

    function automatic string scu_tag(input int a);
        if (a < 4) return "R2";
        if (a < 12) return "R3";
        return "R4";
    endfunction

    function automatic logic [31:0] scu_read(input int a, input logic c, input logic [7:0] cs);
        if (a < 4) return {31'b0, c};
        if (a < 8) return 32'd3;
        if (a < 12) return {24'b0, cs};
        return 32'd0;
    endfunction

    task automatic access(input logic v, input logic w, input logic [11:0] a,
                          input logic [31:0] d, input logic [1:0] c);
        int rg;
        int ex_core;
        logic [31:0] ex_rd;
        @(negedge clk);
        req_valid  = v;
        req_write  = w;
        req_addr   = a;
        req_wdata  = d;
        req_core   = c;
        core_state = 8'($urandom);
        ic_rdata   = $urandom;
        tm_rdata   = $urandom;
        #1;
        rg = region_of(int'(a));
        if (!v) begin
            chk("R11", {29'b0, ic_sel, tm_sel, rsp_err}, 32'd0);
        end else begin
            chk((rg == 1) ? "R5" : (rg == 2) ? "R6" : "R11", 32'(ic_sel), 32'(rg == 1 || rg == 2));
            chk((rg == 3) ? "R7" : (rg == 4) ? "R8" : "R11", 32'(tm_sel), 32'(rg == 3 || rg == 4));
            chk("R9", 32'(rsp_err), 32'(rg == 5));
            ex_rd = 32'd0;
            case (rg)
                0: ex_rd = scu_read(int'(a), ctl_m, core_state);
                1, 2: ex_rd = ic_rdata;
                3, 4: ex_rd = tm_rdata;
                default: ex_rd = 32'd0;
            endcase
            if (!w) chk((rg == 0) ? scu_tag(int'(a)) : (rg == 5) ? "R9" : "R10", rsp_rdata, ex_rd);
            if (rg == 1 || rg == 2) begin
                ex_core = (rg == 1) ? int'(c) : (int'(a) - 'h200) / 256;
                chk((rg == 1) ? "R5" : "R6", 32'(ic_core), 32'(ex_core));
                chk((rg == 1) ? "R5" : "R6", 32'(ic_off), int'(a) % 256);
            end
            if (rg == 3 || rg == 4) begin
                ex_core = (rg == 3) ? int'(c) : (int'(a) - 'h700) / 256;
                chk((rg == 3) ? "R7" : "R8", 32'(tm_idx), 32'(ex_core * 2 + int'(a[5])));
                chk((rg == 3) ? "R7" : "R8", 32'(tm_off), int'(a) % 16);
            end
        end
        @(posedge clk);
        if (v && w && int'(a) < 4) ctl_m = d[0];
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", {29'b0, ic_sel, tm_sel, rsp_err}, 32'd0);
        rst_n = 1'b1;
        // R1: control reads zero after reset
        access(1, 0, 12'h000, 0, 0);
        // R2: only bit 0 kept
        access(1, 1, 12'h000, 32'hFFFF_FFFE, 0);
        access(1, 0, 12'h000, 0, 1);
        access(1, 1, 12'h002, 32'hFFFF_FFFF, 2);
        access(1, 0, 12'h000, 0, 3);
        // R3: writes to read-only and invalidate offsets leave control alone
        access(1, 1, 12'h004, 0, 0);
        access(1, 1, 12'h008, 0, 0);
        access(1, 1, 12'h00C, 0, 0);
        access(1, 0, 12'h004, 0, 0);
        access(1, 0, 12'h008, 0, 0);
        access(1, 0, 12'h000, 0, 0);
        // R4: unimplemented reads return zero
        access(1, 0, 12'h00C, 0, 0);
        access(1, 0, 12'h0FC, 0, 0);
        // R9: out-of-range write aliasing control low bits must not store
        access(1, 1, 12'hB00, 0, 0);
        access(1, 1, 12'hF00, 0, 1);
        access(1, 0, 12'h000, 0, 0);
        access(1, 0, 12'hFFF, 0, 0);
        // window edges, R5 R6 R7 R8
        access(1, 0, 12'h100, 0, 2);
        access(1, 0, 12'h1FF, 0, 3);
        access(1, 0, 12'h200, 0, 1);
        access(1, 1, 12'h5FF, 32'h1, 0);
        access(1, 0, 12'h620, 0, 3);
        access(1, 0, 12'h6FF, 0, 1);
        access(1, 0, 12'h700, 0, 2);
        access(1, 0, 12'hAFF, 0, 0);
        access(0, 1, 12'h100, 0, 0);
        for (int i = 0; i < 600; i++) begin
            logic [11:0] ra;
            ra = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 'h1F)) : 12'($urandom_range(0, 'hFFF));
            if ($urandom_range(0, 7) == 0) ra = 12'h000;
            access(($urandom_range(0, 9) != 0), 1'($urandom), ra, $urandom, 2'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule